// File: doc/BRIEF.md
# Display Power Sequencer

This block drives the power rails of a display controller up or down by issuing an ordered list of register writes, with fixed millisecond waits between some of them. A single request input states whether the panel should be powered. When that request differs from the stored power state and the block is idle, the block starts the matching sequence. Each write offers an 8-bit register offset and a 16-bit value to a register access engine through a request/acknowledge handshake.

The waits are timed by a millisecond tick from a prescaler. The prescaler restarts at the beginning of every wait, so every wait lasts exactly its stated number of milliseconds. The block reports whether it is busy and which power state it currently holds. The stored state changes only when a sequence reaches its end. An error reported by the access engine abandons the sequence and leaves the stored state as it was.

Top module: `panel_power_seq`

## Requirements
- R1: After reset the stored state is off (`isOn`=0), `busy` is 0 and `wrReq` is 0.
- R2: The power-down sequence writes 0x0000 to offset 0x10, waits the short wait, writes 0x0000 to 0x11 and then to 0x12, waits the long wait, writes 0x0000 to 0x13, and waits the long wait.
- R3: The power-up sequence first runs the whole power-down sequence (R2). It then writes 0x080F to 0x56 and 0x4240 to 0x10, waits the short wait, writes 0x0000 to 0x11 and 0x0014 to 0x12, waits the long wait, writes 0x1319 to 0x13, and waits the long wait.
- R4: A wait of M ms (short M=SHORT_MS, default 10; long M=LONG_MS, default 40) holds `wrReq` low for exactly M*CLK_PER_MS cycles, plus one decode cycle before and one after. Between two writes separated by a wait there are M*CLK_PER_MS+2 cycles with `busy`=1 and `wrReq`=0. Between two adjacent writes, and before the first write, there is 1 such cycle.
- R5: While idle, a request equal to the stored state (`reqOn`==`isOn`) starts nothing; `busy` stays 0.
- R6: `isOn` takes the requested value only at the end of the final wait of a completed sequence. `busy` falls in the same cycle.
- R7: Changes on `reqOn` while `busy` is 1 are ignored. When the block returns to idle, the value of `reqOn` at that time decides whether a new sequence starts, one cycle later.
- R8: `wrErr` sampled while a write is offered ends the sequence at once. `busy` and `wrReq` are 0 in the next cycle, and `isOn` is unchanged.
- R9: `wrReq` with its offset and value stays high and stable until `wrAck` or `wrErr` is sampled. Each `wrAck` completes exactly one write, and `wrReq` is low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqOn | input | 1 | Requested power class (1 = powered) |
| wrAck | input | 1 | Access engine accepted the offered write |
| wrErr | input | 1 | Access engine failed the offered write |
| wrReq | output | 1 | A register write is offered |
| wrAddr | output | 8 | Register offset of the offered write |
| wrData | output | 16 | Value of the offered write |
| busy | output | 1 | A sequence is in progress |
| isOn | output | 1 | Stored power state |

## Verification
On every cycle, assertions check several properties. The handshake must hold the offered write stable until it is answered. An idle block with a matching request must stay idle. An error must return the block to idle with the state untouched. The stored state may change only when a sequence ends, and the latched target must not move while busy. Each wait must start from a cleared millisecond count and never pass its target. The exact order of offsets and values, the cycle counts of the gaps between writes, the restart caused by a request changed during a sequence, and the retained state after an abort can only be shown by the bench's scenarios, checked against its cycle-by-cycle reference model.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int STEP_W   = 4;
  localparam int OFF_LAST = 6;
  localparam int ON_LAST  = 14;

  typedef enum logic [1:0] {S_IDLE, S_STEP, S_ISSUE, S_DELAY} seqState_t;

  typedef struct packed {
    logic clrStep;
    logic incStep;
    logic startWait;
  } seqStrobe_t;

  typedef struct packed {
    logic        isWait;
    logic        isLong;
    logic [7:0]  addr;
    logic [15:0] data;
  } stepInfo_t;

  function automatic stepInfo_t stepLookup(input logic [STEP_W-1:0] idx);
    stepInfo_t s;
    s = '{isWait: 1'b0, isLong: 1'b0, addr: 8'h00, data: 16'h0000};
    case (idx)
      4'd0:  s.addr = 8'h10;
      4'd1:  s.isWait = 1'b1;
      4'd2:  s.addr = 8'h11;
      4'd3:  s.addr = 8'h12;
      4'd4:  begin s.isWait = 1'b1; s.isLong = 1'b1; end
      4'd5:  s.addr = 8'h13;
      4'd6:  begin s.isWait = 1'b1; s.isLong = 1'b1; end
      4'd7:  begin s.addr = 8'h56; s.data = 16'h080F; end
      4'd8:  begin s.addr = 8'h10; s.data = 16'h4240; end
      4'd9:  s.isWait = 1'b1;
      4'd10: s.addr = 8'h11;
      4'd11: begin s.addr = 8'h12; s.data = 16'h0014; end
      4'd12: begin s.isWait = 1'b1; s.isLong = 1'b1; end
      4'd13: begin s.addr = 8'h13; s.data = 16'h1319; end
      default: begin s.isWait = 1'b1; s.isLong = 1'b1; end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pwrseq_datapath.sv
module pwrseq_datapath
  import pwrseq_pkg::*;
#(
  parameter int CLK_PER_MS = 125000,
  parameter int SHORT_MS   = 10,
  parameter int LONG_MS    = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobe_t  stb,
  input  logic        tgtOn,
  output logic        curIsWait,
  output logic        atLast,
  output logic        waitDone,
  output logic [7:0]  wrAddr,
  output logic [15:0] wrData
);

  localparam int PRE_W = $clog2(CLK_PER_MS + 1);
  localparam int MS_W  = $clog2(LONG_MS + 1);

  logic [STEP_W-1:0] stepQ;
  logic [PRE_W-1:0]  preQ;
  logic [MS_W-1:0]   msQ;
  logic [MS_W-1:0]   msTarget;
  logic              running;
  logic              tick;
  stepInfo_t         info;

  always_comb begin
    info      = stepLookup(stepQ);
    curIsWait = info.isWait;
    wrAddr    = info.addr;
    wrData    = info.data;
    msTarget  = info.isLong ? MS_W'(LONG_MS) : MS_W'(SHORT_MS);
    tick      = running && (preQ == PRE_W'(CLK_PER_MS - 1));
    waitDone  = tick && (msQ == msTarget - 1'b1);
    atLast    = stepQ == (tgtOn ? STEP_W'(ON_LAST) : STEP_W'(OFF_LAST));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stepQ   <= '0;
      preQ    <= '0;
      msQ     <= '0;
      running <= 1'b0;
    end else begin
      if (stb.clrStep)      stepQ <= '0;
      else if (stb.incStep) stepQ <= stepQ + 1'b1;

      if (stb.startWait) begin
        preQ    <= '0;
        msQ     <= '0;
        running <= 1'b1;
      end else if (running) begin
        if (tick) begin
          preQ <= '0;
          if (waitDone) running <= 1'b0;
          else          msQ     <= msQ + 1'b1;
        end else begin
          preQ <= preQ + 1'b1;
        end
      end
    end
  end

  // R4: a running wait never reaches its own millisecond target
  p_ms_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (msQ < msTarget));

  // R4: every wait starts from a cleared prescaler and count
  p_fresh_wait_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.startWait |=> (running && preQ == '0 && msQ == '0));

endmodule

// File: rtl/pwrseq_ctrl.sv
module pwrseq_ctrl
  import pwrseq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqOn,
  input  logic       wrAck,
  input  logic       wrErr,
  input  logic       curIsWait,
  input  logic       atLast,
  input  logic       waitDone,
  output seqStrobe_t stb,
  output logic       tgtOn,
  output logic       wrReq,
  output logic       busy,
  output logic       isOn
);

  seqState_t stQ, stNxt;
  logic      isOnQ, tgtQ, finish;

  always_comb begin
    stb    = '0;
    stNxt  = stQ;
    finish = 1'b0;
    case (stQ)
      S_IDLE:
        if (reqOn != isOnQ) begin
          stb.clrStep = 1'b1;
          stNxt       = S_STEP;
        end
      S_STEP:
        if (curIsWait) begin
          stb.startWait = 1'b1;
          stNxt         = S_DELAY;
        end else begin
          stNxt = S_ISSUE;
        end
      S_ISSUE:
        if (wrErr) begin
          stNxt = S_IDLE;
        end else if (wrAck) begin
          if (atLast) begin
            finish = 1'b1;
            stNxt  = S_IDLE;
          end else begin
            stb.incStep = 1'b1;
            stNxt       = S_STEP;
          end
        end
      default:
        if (waitDone) begin
          if (atLast) begin
            finish = 1'b1;
            stNxt  = S_IDLE;
          end else begin
            stb.incStep = 1'b1;
            stNxt       = S_STEP;
          end
        end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stQ   <= S_IDLE;
      isOnQ <= 1'b0;
      tgtQ  <= 1'b0;
    end else begin
      stQ <= stNxt;
      if (stQ == S_IDLE && reqOn != isOnQ) tgtQ <= reqOn;
      if (finish) isOnQ <= tgtQ;
    end
  end

  assign tgtOn = tgtQ;
  assign wrReq = (stQ == S_ISSUE);
  assign busy  = (stQ != S_IDLE);
  assign isOn  = isOnQ;

  // R5: matching request while idle keeps the block idle
  p_same_class_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == S_IDLE && reqOn == isOnQ) |=> (stQ == S_IDLE));

  // R8: an error on an offered write aborts without touching the state
  p_err_abort_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == S_ISSUE && wrErr) |=> (stQ == S_IDLE && $stable(isOnQ)));

  // R6: the stored state only moves at the end of a busy period
  p_state_at_end_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(isOnQ) |-> ($past(stQ) != S_IDLE && stQ == S_IDLE));

  // R7: the latched target is frozen while a sequence runs
  p_target_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stQ != S_IDLE) |=> $stable(tgtQ));

endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq
  import pwrseq_pkg::*;
#(
  parameter int CLK_PER_MS = 125000,
  parameter int SHORT_MS   = 10,
  parameter int LONG_MS    = 40
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqOn,
  input  logic        wrAck,
  input  logic        wrErr,
  output logic        wrReq,
  output logic [7:0]  wrAddr,
  output logic [15:0] wrData,
  output logic        busy,
  output logic        isOn
);

  seqStrobe_t stb;
  logic       tgtOn, curIsWait, atLast, waitDone;

  pwrseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqOn(reqOn), .wrAck(wrAck), .wrErr(wrErr),
    .curIsWait(curIsWait), .atLast(atLast), .waitDone(waitDone),
    .stb(stb), .tgtOn(tgtOn), .wrReq(wrReq), .busy(busy), .isOn(isOn)
  );

  pwrseq_datapath #(
    .CLK_PER_MS(CLK_PER_MS), .SHORT_MS(SHORT_MS), .LONG_MS(LONG_MS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tgtOn(tgtOn),
    .curIsWait(curIsWait), .atLast(atLast), .waitDone(waitDone),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  // R9: an unanswered write stays offered with stable offset and value
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && !wrAck && !wrErr) |=> (wrReq && $stable(wrAddr) && $stable(wrData)));

  // R9: an accepted write is withdrawn in the next cycle
  p_ack_drop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrReq && wrAck) |=> !wrReq);

  // R1: no write is offered while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wrReq);

endmodule

// File: tb/sim_panel_power_seq.sv
`timescale 1ns/1ps
module sim_panel_power_seq;

  localparam int CPM = 3;
  localparam int SMS = 10;
  localparam int LMS = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqOn = 1'b0;
  logic wrAck = 1'b0;
  logic wrErr = 1'b0;
  logic wrReq, busy, isOn;
  logic [7:0]  wrAddr;
  logic [15:0] wrData;

  always #4 clk = ~clk;

  panel_power_seq #(.CLK_PER_MS(CPM), .SHORT_MS(SMS), .LONG_MS(LMS)) u0 (
    .clk(clk), .rstN(rstN), .reqOn(reqOn), .wrAck(wrAck), .wrErr(wrErr),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrData(wrData), .busy(busy), .isOn(isOn)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int  qAddr[$], qData[$], qMs[$];
  int  mPhase = 0;   // 0 idle, 1 decode gap, 2 write offered, 3 waiting
  int  mCnt = 0;
  bit  mOn = 0, mTgt = 0;

  function automatic void addStep(int a, int d, int ms);
    qAddr.push_back(a); qData.push_back(d); qMs.push_back(ms);
  endfunction

  function automatic void loadSeq(bit up);
    addStep('h10, 0, 0); addStep(0, 0, SMS); addStep('h11, 0, 0);
    addStep('h12, 0, 0); addStep(0, 0, LMS); addStep('h13, 0, 0);
    addStep(0, 0, LMS);
    if (up) begin
      addStep('h56, 'h080F, 0); addStep('h10, 'h4240, 0); addStep(0, 0, SMS);
      addStep('h11, 0, 0); addStep('h12, 'h0014, 0); addStep(0, 0, LMS);
      addStep('h13, 'h1319, 0); addStep(0, 0, LMS);
    end
  endfunction

  function automatic void popNext();
    void'(qAddr.pop_front()); void'(qData.pop_front()); void'(qMs.pop_front());
    if (qMs.size() == 0) begin mOn = mTgt; mPhase = 0; end
    else mPhase = 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mOn = 0; mTgt = 0;
      qAddr.delete(); qData.delete(); qMs.delete();
    end else begin
      case (mPhase)
        0: if (reqOn != mOn) begin mTgt = reqOn; loadSeq(reqOn); mPhase = 1; end
        1: if (qMs[0] == 0) mPhase = 2;
           else begin mPhase = 3; mCnt = qMs[0] * CPM; end
        2: if (wrErr) begin
             qAddr.delete(); qData.delete(); qMs.delete(); mPhase = 0;
           end else if (wrAck) popNext();
        default: begin mCnt--; if (mCnt == 0) popNext(); end
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !finished) begin
      chk(busy === (mPhase != 0), "R7 busy vs model", busy, mPhase != 0);
      chk(isOn === mOn, "R6 isOn vs model", isOn, mOn);
      chk(wrReq === (mPhase == 2), "R9 wrReq vs model", wrReq, mPhase == 2);
      if (mPhase == 2 && wrReq === 1'b1) begin
        chk(wrAddr == 8'(qAddr[0]), "R2 R3 offset vs model", wrAddr, qAddr[0]);
        chk(wrData == 16'(qData[0]), "R2 R3 value vs model", wrData, qData[0]);
      end
    end
  end

  // ---------------- access engine responder and write log ----------------
  int  ackLat = 0;
  bit  errArm = 0;
  int  errAddr = 0;
  int  gap = 0;
  int  logAddr[$], logData[$], logGap[$];

  function automatic void logClear();
    logAddr.delete(); logData.delete(); logGap.delete(); gap = 0;
  endfunction

  initial begin
    int wcnt = 0;
    forever begin
      @(posedge clk); #2;
      wrAck = 1'b0; wrErr = 1'b0;
      if (!rstN) begin wcnt = 0; continue; end
      if (busy && !wrReq) gap++;
      if (wrReq) begin
        if (errArm && wrAddr == 8'(errAddr)) begin
          wrErr = 1'b1; errArm = 0; reqOn = 1'b0; wcnt = 0;
        end else if (wcnt >= ackLat) begin
          wrAck = 1'b1; wcnt = 0;
          logAddr.push_back(wrAddr); logData.push_back(wrData);
          logGap.push_back(gap); gap = 0;
        end else wcnt++;
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic waitIdle();
    int quiet = 0;
    while (quiet < 3) begin
      @(negedge clk);
      if (!busy) quiet++; else quiet = 0;
    end
  endtask

  task automatic waitBusy();
    while (busy !== 1'b1) @(negedge clk);
  endtask

  initial begin
    int onA[9] = '{'h10, 'h11, 'h12, 'h13, 'h56, 'h10, 'h11, 'h12, 'h13};
    int onD[9] = '{0, 0, 0, 0, 'h080F, 'h4240, 0, 'h0014, 'h1319};
    int onG[9] = '{1, SMS*CPM+2, 1, LMS*CPM+2, LMS*CPM+2, 1, SMS*CPM+2, 1, LMS*CPM+2};
    int offG[4] = '{1, SMS*CPM+2, 1, LMS*CPM+2};

    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(isOn == 1'b0, "R1 isOn after reset", isOn, 0);
    chk(busy == 1'b0, "R1 busy after reset", busy, 0);
    chk(wrReq == 1'b0, "R1 wrReq after reset", wrReq, 0);

    // R5: request equal to the stored state does nothing
    reqOn = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R5 no sequence for same class", busy, 0);
    chk(logAddr.size() == 0, "R5 no write for same class", logAddr.size(), 0);

    // R3 R4 R7: power up, with request toggles while busy
    logClear(); ackLat = 2;
    reqOn = 1'b1;
    waitBusy();
    repeat (30) @(negedge clk);
    reqOn = 1'b0;
    repeat (30) @(negedge clk);
    reqOn = 1'b1;
    waitIdle();
    chk(isOn == 1'b1, "R6 isOn after power-up", isOn, 1);
    chk(logAddr.size() == 9, "R3 write count power-up", logAddr.size(), 9);
    if (logAddr.size() == 9)
      for (int i = 0; i < 9; i++) begin
        chk(logAddr[i] == onA[i], "R3 power-up offset", logAddr[i], onA[i]);
        chk(logData[i] == onD[i], "R3 power-up value", logData[i], onD[i]);
        chk(logGap[i] == onG[i], "R4 power-up gap", logGap[i], onG[i]);
      end

    // R2 R4: power down with immediate acknowledge
    logClear(); ackLat = 0;
    reqOn = 1'b0;
    waitIdle();
    chk(isOn == 1'b0, "R6 isOn after power-down", isOn, 0);
    chk(logAddr.size() == 4, "R2 write count power-down", logAddr.size(), 4);
    if (logAddr.size() == 4)
      for (int i = 0; i < 4; i++) begin
        chk(logAddr[i] == onA[i], "R2 power-down offset", logAddr[i], onA[i]);
        chk(logData[i] == 0, "R2 power-down value", logData[i], 0);
        chk(logGap[i] == offG[i], "R4 power-down gap", logGap[i], offG[i]);
      end

    // R7: request dropped while busy and left there runs power-down afterwards
    logClear(); ackLat = 1;
    reqOn = 1'b1;
    waitBusy();
    repeat (10) @(negedge clk);
    reqOn = 1'b0;
    waitIdle();
    chk(isOn == 1'b0, "R7 last idle request acted on", isOn, 0);
    chk(logAddr.size() == 13, "R7 up then down write count", logAddr.size(), 13);
    if (logAddr.size() == 13)
      chk(logGap[9] == LMS*CPM+2, "R7 restart gap", logGap[9], LMS*CPM+2);

    // R8: error on the write to 0x12 aborts power-up
    logClear(); ackLat = 0;
    errAddr = 'h12; errArm = 1;
    reqOn = 1'b1;
    waitIdle();
    chk(isOn == 1'b0, "R8 isOn kept after abort", isOn, 0);
    chk(busy == 1'b0, "R8 idle after abort", busy, 0);
    chk(logAddr.size() == 2, "R8 writes before abort", logAddr.size(), 2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule